// File: doc/BRIEF.md
# Baseband Sample Input Stage

This block is the entry point of a baseband demodulation pipeline. It takes 10-bit in-phase (I) and quadrature (Q) samples in one of two forms. In parallel form a whole sample pair is presented on two buses together with an active-low enable. In serial form the two components arrive one bit at a time on two pins, clocked by a slower serial clock and framed by a word-start sync. Whichever form is selected, the block hands the pair to the downstream pipeline as registered two's complement words plus a one-clock valid strobe.

A format control tells the block whether incoming samples use two's complement or offset binary. Offset-binary samples are converted by inverting the most significant bit, so downstream logic always sees two's complement. The serial clock is sampled by the processing clock and acted on at its rising edges. A word-start sync seen at one such edge marks the next ten serial clocks as data bits, sent MSB first. After those ten bits the shift registers freeze and keep their word until the next sync. That sync is what delivers the held word to the pipeline and restarts shifting.

Top module: `baseband_sample_input`

## Requirements
- R1: After reset, outValid is 0 and outI and outQ are 0. The serial shift registers are cleared and frozen, so a sync arriving before any bit is shifted delivers the word 0.
- R2: In parallel mode (serialMode = 0), each clk edge that samples parSyncN low captures parI and parQ. outValid is 1 in the following cycle with the captured pair. A clk edge that samples parSyncN high leaves outValid at 0 in the following cycle.
- R3: With offsetBin = 1, bit 9 (the MSB) of each delivered word is the inverse of the input's bit 9, and bits 8 to 0 pass unchanged. With offsetBin = 0, the word passes unchanged. The value of offsetBin at the load edge applies.
- R4: In serial mode (serialMode = 1), a serial clock rising edge is acted on at the first clk edge that samples serClk high after sampling it low. If serSync is sampled high at that edge, outValid is 1 for exactly the following cycle and the held I/Q words are delivered.
- R5: After a sync, each of the next 10 serial clock rising edges shifts both registers left by one and puts serI/serQ into bit 0. Ten bits sent MSB first therefore form the delivered word.
- R6: Once 10 bits have been shifted, further serial clock edges with serSync low change nothing. The next sync delivers the ten-bit word unchanged.
- R7: A sync that arrives after fewer than 10 bits delivers the registers as they stand: the previous contents shifted left by the number of bits received, with the new bits in the low positions. No error is indicated.
- R8: In serial mode, parSyncN has no effect on outValid, outI or outQ. In parallel mode, serial clock edges with serSync high produce no outValid pulse.
- R9: Between valid pulses, outI and outQ hold the last delivered pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | 1 selects serial input, 0 selects parallel input |
| offsetBin | input | 1 | 1 means inputs are offset binary, 0 means two's complement |
| parI | input | 10 | Parallel in-phase sample |
| parQ | input | 10 | Parallel quadrature sample |
| parSyncN | input | 1 | Active-low parallel capture enable |
| serClk | input | 1 | Serial bit clock, sampled by clk |
| serSync | input | 1 | Serial word-start sync, active high for one serial clock |
| serI | input | 1 | Serial in-phase data bit |
| serQ | input | 1 | Serial quadrature data bit |
| outI | output | 10 | Delivered in-phase sample, two's complement |
| outQ | output | 10 | Delivered quadrature sample, two's complement |
| outValid | output | 1 | One-cycle strobe marking a new delivered pair |

## Verification
Parallel capture is tried with all-zero, all-one, sign-only and largest-positive words under both formats. These patterns separate a correct MSB inversion from a passthrough or from an inversion of the wrong bit. Serial capture is driven with complete ten-bit words, with words followed by surplus bits, and with syncs after zero to thirteen bits. These separate correct MSB-first order, freezing after ten bits and partial delivery from a register that keeps shifting or clears at sync. Random words, random enable gaps and random mode and format changes, with parallel strobes sent in serial mode and syncs sent in parallel mode, show that each path ignores the other.

// File: rtl/bsi_pkg.sv
package bsi_pkg;

  // Strobes from the control to the datapath, one clk cycle wide each.
  typedef struct packed {
    logic loadPar;   // capture the parallel buses into the output registers
    logic loadSer;   // hand the held serial word to the output registers
    logic shiftEn;   // shift one serial bit into both shift registers
  } bsiStrobes_t;

endpackage

// File: rtl/bsi_control.sv
module bsi_control
  import bsi_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serialMode,
  input  logic        parSyncN,
  input  logic        serClk,
  input  logic        serSync,
  output bsiStrobes_t strobes
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SAMPLE_W);

  logic             serClkD;
  logic             serRise;
  logic [CNT_W-1:0] bitCnt;
  logic             shiftOpen;

  // Serial clock is treated as synchronous: rising edge found by one delay stage.
  always_ff @(posedge clk) begin
    if (!rstN) serClkD <= 1'b0;
    else       serClkD <= serClk;
  end

  assign serRise   = serClk & ~serClkD;
  assign shiftOpen = (bitCnt < FULL_CNT);

  always_comb begin
    strobes         = '0;
    strobes.loadPar = ~serialMode & ~parSyncN;
    strobes.loadSer = serialMode & serRise & serSync;
    strobes.shiftEn = serialMode & serRise & ~serSync & shiftOpen;
  end

  // Bit counter: reset value is full so the register is frozen until a sync.
  always_ff @(posedge clk) begin
    if (!rstN)                bitCnt <= FULL_CNT;
    else if (strobes.loadSer) bitCnt <= '0;
    else if (strobes.shiftEn) bitCnt <= bitCnt + CNT_W'(1);
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);

  // R4
  ser_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSer |=> !strobes.loadSer);

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSer |=> (bitCnt == '0));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (bitCnt == $past(bitCnt) + CNT_W'(1)));

  // R8
  par_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    serialMode |-> !strobes.loadPar);

endmodule

// File: rtl/bsi_datapath.sv
module bsi_datapath
  import bsi_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                offsetBin,
  input  bsiStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] parI,
  input  logic [SAMPLE_W-1:0] parQ,
  input  logic                serI,
  input  logic                serQ,
  output logic [SAMPLE_W-1:0] outI,
  output logic [SAMPLE_W-1:0] outQ,
  output logic                outValid
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] shiftI, shiftQ;
  logic [SAMPLE_W-1:0] srcI, srcQ;
  logic [SAMPLE_W-1:0] fmtI, fmtQ;
  logic                loadAny;

  // Serial shift registers, MSB first, new bit enters at bit 0.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftI <= '0;
      shiftQ <= '0;
    end else if (strobes.shiftEn) begin
      shiftI <= {shiftI[MSB-1:0], serI};
      shiftQ <= {shiftQ[MSB-1:0], serQ};
    end
  end

  assign loadAny = strobes.loadPar | strobes.loadSer;
  assign srcI    = strobes.loadSer ? shiftI : parI;
  assign srcQ    = strobes.loadSer ? shiftQ : parQ;

  // Offset binary to two's complement: flip the sign bit.
  always_comb begin
    fmtI      = srcI;
    fmtQ      = srcQ;
    fmtI[MSB] = srcI[MSB] ^ offsetBin;
    fmtQ[MSB] = srcQ[MSB] ^ offsetBin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI     <= '0;
      outQ     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= loadAny;
      if (loadAny) begin
        outI <= fmtI;
        outQ <= fmtQ;
      end
    end
  end

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> ($stable(shiftI) && $stable(shiftQ)));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadAny |=> ($stable(outI) && $stable(outQ) && !outValid));

  // R4
  ser_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSer && !offsetBin) |=> (outValid && outI == $past(shiftI)
                                          && outQ == $past(shiftQ)));

  // R3
  fmt_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPar |=> (outI[MSB-1:0] == $past(parI[MSB-1:0])));

endmodule

// File: rtl/baseband_sample_input.sv
module baseband_sample_input #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialMode,
  input  logic                offsetBin,
  input  logic [SAMPLE_W-1:0] parI,
  input  logic [SAMPLE_W-1:0] parQ,
  input  logic                parSyncN,
  input  logic                serClk,
  input  logic                serSync,
  input  logic                serI,
  input  logic                serQ,
  output logic [SAMPLE_W-1:0] outI,
  output logic [SAMPLE_W-1:0] outQ,
  output logic                outValid
);

  bsi_pkg::bsiStrobes_t strobes;

  bsi_control #(.SAMPLE_W(SAMPLE_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .serialMode (serialMode),
    .parSyncN   (parSyncN),
    .serClk     (serClk),
    .serSync    (serSync),
    .strobes    (strobes)
  );

  bsi_datapath #(.SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .offsetBin (offsetBin),
    .strobes   (strobes),
    .parI      (parI),
    .parQ      (parQ),
    .serI      (serI),
    .serQ      (serQ),
    .outI      (outI),
    .outQ      (outQ),
    .outValid  (outValid)
  );

endmodule

// File: tb/baseband_sample_input_tb.sv
module baseband_sample_input_tb;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         serialMode = 1'b0;
  logic         offsetBin = 1'b0;
  logic [W-1:0] parI = '0;
  logic [W-1:0] parQ = '0;
  logic         parSyncN = 1'b1;
  logic         serClk = 1'b0;
  logic         serSync = 1'b0;
  logic         serI = 1'b0;
  logic         serQ = 1'b0;
  logic [W-1:0] outI, outQ;
  logic         outValid;

  int vecCnt = 0;
  int missCnt = 0;

  // Bench model of the serial word registers and bit count.
  logic [W-1:0] mShI = '0;
  logic [W-1:0] mShQ = '0;
  int           mCnt = W;
  logic [W-1:0] lastI = '0;
  logic [W-1:0] lastQ = '0;

  baseband_sample_input #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .offsetBin(offsetBin),
    .parI(parI), .parQ(parQ), .parSyncN(parSyncN), .serClk(serClk),
    .serSync(serSync), .serI(serI), .serQ(serQ),
    .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  always #2 clk = ~clk;

  function automatic logic [W-1:0] fmt(input logic [W-1:0] x, input logic ob);
    fmt = ob ? (x ^ (1 << (W-1))) : x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic v, input logic [W-1:0] ei,
                          input logic [W-1:0] eq);
    check(req, {31'd0, outValid}, {31'd0, v});
    check(req, {22'd0, outI}, {22'd0, ei});
    check(req, {22'd0, outQ}, {22'd0, eq});
  endtask

  // Parallel strobe; called at a negedge.
  task automatic parSample(input logic [W-1:0] i, input logic [W-1:0] q, input logic en);
    logic expV;
    parI = i; parQ = q; parSyncN = ~en;
    expV = en && !serialMode;
    if (expV) begin lastI = fmt(i, offsetBin); lastQ = fmt(q, offsetBin); end
    @(negedge clk);
    parSyncN = 1'b1;
    if (expV) checkOut("R2/R3 parallel capture", 1'b1, lastI, lastQ);
    else      checkOut("R8/R9 no capture", 1'b0, lastI, lastQ);
  endtask

  // One serial clock period; called at a negedge.
  task automatic serBit(input logic s, input logic bi, input logic bq);
    logic expV;
    serSync = s; serI = bi; serQ = bq; serClk = 1'b1;
    expV = 1'b0;
    if (serialMode) begin
      if (s) begin
        expV = 1'b1;
        lastI = fmt(mShI, offsetBin); lastQ = fmt(mShQ, offsetBin);
        mCnt = 0;
      end else if (mCnt < W) begin
        mShI = {mShI[W-2:0], bi}; mShQ = {mShQ[W-2:0], bq};
        mCnt++;
      end
    end
    @(negedge clk);
    if (expV) checkOut("R4/R5/R6/R7 serial word", 1'b1, lastI, lastQ);
    else if (s) check("R8 sync in parallel mode", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    serClk = 1'b0; serSync = 1'b0;
    if (s) check("R4 single valid", {31'd0, outValid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic serWord(input logic [W-1:0] wi, input logic [W-1:0] wq, input int nBits);
    serBit(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < nBits; k++) begin
      serBit(1'b0, wi[(W-1-k) % W], wq[(W-1-k) % W]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    logic [31:0] seedJunk;
    seedJunk = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    // R1 reset state
    checkOut("R1 reset", 1'b0, '0, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release", 1'b0, '0, '0);

    // R2 / R3 directed parallel corners
    parSample(10'h000, 10'h3FF, 1'b1);
    parSample(10'h200, 10'h1FF, 1'b1);
    offsetBin = 1'b1;
    parSample(10'h000, 10'h3FF, 1'b1);
    parSample(10'h200, 10'h1FF, 1'b1);
    offsetBin = 1'b0;
    // R9 hold with enable high
    parSample(10'h155, 10'h0AA, 1'b0);
    parSample(10'h2AA, 10'h133, 1'b0);
    // R8 serial sync while in parallel mode
    serBit(1'b1, 1'b1, 1'b1);
    check("R8 outputs held", {22'd0, outI}, {22'd0, lastI});

    // Serial: R1 first sync after reset delivers zero
    serialMode = 1'b1;
    @(negedge clk);
    serBit(1'b1, 1'b0, 1'b0);
    check("R1 first serial word zero", {22'd0, outI}, 32'd0);
    // R5 full word, R6 surplus bits ignored
    for (int k = 0; k < W; k++) serBit(1'b0, 1'(10'h2C5 >> (W-1-k)), 1'(10'h13A >> (W-1-k)));
    for (int k = 0; k < 3; k++) serBit(1'b0, 1'b1, 1'b0);
    serBit(1'b1, 1'b0, 1'b0);
    check("R5/R6 word MSB first", {22'd0, outI}, 32'h2C5);
    check("R5/R6 word MSB first Q", {22'd0, outQ}, 32'h13A);
    // R7 partial word: 4 bits 1011 after full word 2C5/13A
    for (int k = 0; k < 4; k++) serBit(1'b0, 1'(4'b1011 >> (3-k)), 1'b0);
    serBit(1'b1, 1'b0, 1'b0);
    check("R7 partial word", {22'd0, outI}, 32'h05B);
    // R8 parallel strobe in serial mode
    parSample(10'h3C3, 10'h3C3, 1'b1);
    // R3 offset binary on serial
    offsetBin = 1'b1;
    serWord(10'h0F0, 10'h30F, W);
    serBit(1'b1, 1'b0, 1'b0);
    check("R3 serial offset", {22'd0, outI}, 32'h2F0);
    offsetBin = 1'b0;

    // Random mixed traffic
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) serialMode = ~serialMode;
      if (r == 1) offsetBin = ~offsetBin;
      if ($urandom_range(0, 1) == 1)
        parSample(W'($urandom), W'($urandom), 1'($urandom_range(0, 2) != 0));
      else
        serWord(W'($urandom), W'($urandom), $urandom_range(0, 13));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule